// File: doc/BRIEF.md
# Minimum-Frequency Clock Monitor

This block watches a monitored clock (the instruction-cycle clock) and raises an active-low error request when that clock runs too slowly or stops. A free-running slow reference clock marks out measurement periods. In each reference period the monitored domain counts its own edges. A period that holds fewer edges than a programmable minimum is a fault. A separate path in the reference domain detects a monitored clock that has stopped, so a dead oscillator is reported even though the monitored domain can no longer act.

The error request is meant to be combined with the watchdog's own active-low request onto one shared pin. The enable input comes from the latched enable bit of the watchdog service register. That bit is set out of reset, so an oscillator that never starts gives a continuous error. Once the clock is back at full rate, the request is released a fixed number of monitored cycles later. Between the pass threshold and the reject threshold there is a band where either outcome is allowed.

Top module: `clkmon_minfreq`

## Requirements
- R1: With mon_en high and no monitored-clock edge after reset release, err_n is low within 10 reference periods and stays low.
- R2: While rst_n is low, err_n is high, whatever the clocks and mon_en do, including when reset is applied during a fault.
- R3: A monitored clock giving at least MIN_CNT+2 cycles (4 by default) in every reference period never holds err_n low once any earlier fault has been released.
- R4: A monitored clock giving fewer than MIN_CNT edges (2 by default) in each reference period drives err_n low.
- R5: A monitored clock that stops drives err_n low within 10 reference periods, without needing any monitored-clock edge, provided mon_en is high.
- R6: While the fault condition persists, err_n stays low on every sample, with no gaps.
- R7: After recovery, err_n returns high no sooner than REL_CYC (16) monitored cycles after the first good period boundary. A short period or a stall during that delay starts the delay again.
- R8: While mon_en is low, err_n is high and the fault state is cleared, for a slow clock as well as a stopped one.
- R9: The fault state is entered only at a reference-period boundary with a short count, or on a stall. Toggling mon_en with a full-rate clock raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Monitored clock whose frequency is checked |
| ref_clk | input | 1 | Free-running slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mon_en | input | 1 | Latched monitor enable from the watchdog service register |
| err_n | output | 1 | Active-low clock error request, to be ORed with the watchdog request |

## Verification
The bound checker watches, on every cycle, the following rules. A short period at a boundary always leads to the fault state. The fault state starts only from a short period or a synchronized stall. The fault never clears before REL_CYC consecutive clean monitored cycles have passed. With the enable low, the state clears in both domains. Reset keeps the output inactive. The bench scenarios show the frequency-dependent behaviour that no single-cycle property can express: a clock that never starts, stops partway through, runs just above the pass threshold or below the reject threshold, and how long release takes once a real clock returns.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;

  localparam int unsigned CM_MIN_CNT_DEF   = 2;
  localparam int unsigned CM_REL_CYC_DEF   = 16;
  localparam int unsigned CM_STALL_LIM_DEF = 4;

  // Monitored-domain fault state.
  typedef enum logic [1:0] {
    CM_CLEAR   = 2'd0,
    CM_FAULT   = 2'd1,
    CM_RECOVER = 2'd2
  } cm_state_e;

  // Bits needed to hold values 0..v.
  function automatic int unsigned cm_cw(input int unsigned v);
    if (v < 2) return 1;
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/clkmon_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer; with d tied high it serves as a reset release synchronizer.
module clkmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkmon_ref_side.sv
`timescale 1ns/1ps
// Reference domain: period toggle and stopped-clock detection.
module clkmon_ref_side
  import clkmon_pkg::*;
#(
  parameter int unsigned STALL_LIM   = CM_STALL_LIM_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack_tgl,   // from the monitored domain, flips once per seen boundary
  output logic ref_tgl,
  output logic stall
);
  localparam int unsigned GW = cm_cw(STALL_LIM);

  logic          ack_s;
  logic          tgl_q, tgl_d;
  logic          ack_q, ack_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          stall_q, stall_d;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  always_comb begin
    tgl_d   = ~tgl_q;
    ack_d   = ack_s;
    gap_d   = gap_q;
    stall_d = stall_q;
    if (!en) begin
      gap_d   = '0;
      stall_d = 1'b0;
    end else if (ack_s ^ ack_q) begin
      gap_d   = '0;
      stall_d = 1'b0;
    end else if (gap_q == GW'(STALL_LIM - 1)) begin
      stall_d = 1'b1;
    end else begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q   <= 1'b0;
      ack_q   <= 1'b0;
      gap_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      tgl_q   <= tgl_d;
      ack_q   <= ack_d;
      gap_q   <= gap_d;
      stall_q <= stall_d;
    end
  end

  assign ref_tgl = tgl_q;
  assign stall   = stall_q;
endmodule

// File: rtl/clkmon_mon_side.sv
`timescale 1ns/1ps
// Monitored domain: per-period edge count, fault state and release delay.
module clkmon_mon_side
  import clkmon_pkg::*;
#(
  parameter int unsigned MIN_CNT     = CM_MIN_CNT_DEF,
  parameter int unsigned REL_CYC     = CM_REL_CYC_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_tgl,
  input  logic stall,
  output logic hold,
  output logic ack_tgl,
  output logic short_evt,
  output logic stall_m
);
  localparam int unsigned CW = cm_cw(MIN_CNT);
  localparam int unsigned RW = cm_cw(REL_CYC);

  logic          tgl_s, tgl_q, bnd;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  cm_state_e     st_q, st_d;
  logic [RW-1:0] rel_q, rel_d;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk   (mon_clk),
    .rst_n (rst_n),
    .d     (ref_tgl),
    .q     (tgl_s)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_stall_sync (
    .clk   (mon_clk),
    .rst_n (rst_n),
    .d     (stall),
    .q     (stall_m)
  );

  assign bnd       = tgl_s ^ tgl_q;
  assign short_evt = bnd & (cnt_q < CW'(MIN_CNT));

  always_comb begin
    // saturating edge count, restarted on each period boundary
    if (bnd)                        cnt_d = '0;
    else if (cnt_q == CW'(MIN_CNT)) cnt_d = cnt_q;
    else                            cnt_d = cnt_q + 1'b1;
    ack_d = bnd ? ~ack_q : ack_q;

    st_d  = st_q;
    rel_d = rel_q;
    if (!en) begin
      st_d  = CM_CLEAR;
      rel_d = '0;
    end else if (stall_m || short_evt) begin
      st_d  = CM_FAULT;
      rel_d = '0;
    end else begin
      case (st_q)
        CM_FAULT: begin
          if (bnd) begin
            st_d  = CM_RECOVER;
            rel_d = '0;
          end
        end
        CM_RECOVER: begin
          if (rel_q == RW'(REL_CYC - 1)) begin
            st_d  = CM_CLEAR;
            rel_d = '0;
          end else begin
            rel_d = rel_q + 1'b1;
          end
        end
        default: st_d = CM_CLEAR;
      endcase
    end
  end

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      cnt_q <= '0;
      ack_q <= 1'b0;
      st_q  <= CM_CLEAR;
      rel_q <= '0;
    end else begin
      tgl_q <= tgl_s;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
      st_q  <= st_d;
      rel_q <= rel_d;
    end
  end

  assign hold    = (st_q != CM_CLEAR);
  assign ack_tgl = ack_q;
endmodule

// File: rtl/clkmon_minfreq.sv
`timescale 1ns/1ps
module clkmon_minfreq
  import clkmon_pkg::*;
#(
  parameter int unsigned MIN_CNT     = CM_MIN_CNT_DEF,
  parameter int unsigned REL_CYC     = CM_REL_CYC_DEF,
  parameter int unsigned STALL_LIM   = CM_STALL_LIM_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_en,
  output logic err_n
);
  logic mon_rst_n, ref_rst_n;
  logic ref_tgl_w, ack_w;
  logic hold_w, stall_w, short_w, stall_m_w;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_mon_rst (
    .clk (mon_clk), .rst_n (rst_n), .d (1'b1), .q (mon_rst_n)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk (ref_clk), .rst_n (rst_n), .d (1'b1), .q (ref_rst_n)
  );

  clkmon_ref_side #(
    .STALL_LIM   (STALL_LIM),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ref (
    .ref_clk (ref_clk),
    .rst_n   (ref_rst_n),
    .en      (mon_en),
    .ack_tgl (ack_w),
    .ref_tgl (ref_tgl_w),
    .stall   (stall_w)
  );

  clkmon_mon_side #(
    .MIN_CNT     (MIN_CNT),
    .REL_CYC     (REL_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .mon_clk   (mon_clk),
    .rst_n     (mon_rst_n),
    .en        (mon_en),
    .ref_tgl   (ref_tgl_w),
    .stall     (stall_w),
    .hold      (hold_w),
    .ack_tgl   (ack_w),
    .short_evt (short_w),
    .stall_m   (stall_m_w)
  );

  // stall comes straight from the reference domain: no monitored edge needed
  assign err_n = ~(mon_en & (hold_w | stall_w));
endmodule

// File: rtl/clkmon_minfreq_chk.sv
`timescale 1ns/1ps
module clkmon_minfreq_chk
  import clkmon_pkg::*;
#(
  parameter int unsigned REL_CYC = CM_REL_CYC_DEF
) (
  input logic mon_clk,
  input logic ref_clk,
  input logic rst_n,
  input logic en,
  input logic err_n,
  input logic hold,
  input logic short_evt,
  input logic stall_m,
  input logic stall
);
  localparam int unsigned RW = cm_cw(REL_CYC);

  // consecutive monitored cycles without a fault cause
  logic [RW-1:0] run_q;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)                            run_q <= '0;
    else if (short_evt || stall_m || !en)  run_q <= '0;
    else if (run_q != RW'(REL_CYC))        run_q <= run_q + 1'b1;
  end

  p_reset_quiet_r2: assert property (@(posedge ref_clk)
    !rst_n |-> err_n);

  p_short_faults_r4: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (en && short_evt) |=> (hold || !en));

  p_fault_cause_r9: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(hold) |-> $past(short_evt || stall_m));

  p_release_len_r7: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (en && $fell(hold)) |-> (run_q >= RW'(REL_CYC)));

  p_off_clears_mon_r8: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !en |=> (!hold || en));

  p_off_clears_ref_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !en |=> (!stall || en));
endmodule

bind clkmon_minfreq clkmon_minfreq_chk #(.REL_CYC(REL_CYC)) u_chk (
  .mon_clk   (mon_clk),
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .en        (mon_en),
  .err_n     (err_n),
  .hold      (hold_w),
  .short_evt (short_w),
  .stall_m   (stall_m_w),
  .stall     (stall_w)
);

// File: tb/clkmon_minfreq_tb_top.sv
`timescale 1ns/1ps
module clkmon_minfreq_tb_top;
  localparam int REF_PERIOD = 1000;
  localparam int VEC_N = 9;
  // monitored half period in ns (0 = stopped), enable, expected err_n
  localparam int V_HALF [VEC_N] = '{5, 400, 5, 0, 5, 125, 400, 0, 0};
  localparam bit V_EN   [VEC_N] = '{1, 1, 1, 1, 1, 1, 0, 0, 1};
  localparam bit V_EXP  [VEC_N] = '{1, 0, 1, 0, 1, 1, 1, 1, 0};

  logic mon_clk, ref_clk, rst_n, mon_en, err_n;
  int mon_half = 0;
  int checks = 0;
  int errors = 0;

  clkmon_minfreq dut_i (
    .mon_clk (mon_clk),
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mon_en  (mon_en),
    .err_n   (err_n)
  );

  initial ref_clk = 1'b0;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  // all monitored edges fall on multiples of 5 ns
  initial begin
    mon_clk = 1'b0;
    forever begin
      if (mon_half == 0) #5;
      else begin
        #(mon_half);
        mon_clk = ~mon_clk;
      end
    end
  end

  function automatic string vec_req(input int i);
    case (i)
      1:       return "R4";
      3, 8:    return "R5";
      6, 7:    return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // sample 3 ns after a reference falling edge, away from every clock edge
  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
    #3;
  endtask

  task automatic hold_check(input logic exp, input string req, input string what);
    logic got;
    got = exp;
    for (int k = 0; k < 4; k++) begin
      wait_ref(1);
      if (err_n !== exp) got = err_n;
    end
    chk(got, exp, req, what);
  endtask

  initial begin
    #(REF_PERIOD * 1000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic up;
    rst_n  = 1'b1;
    mon_en = 1'b1;
    #1 rst_n = 1'b0;

    // R2: inactive during reset even with a dead clock
    wait_ref(5);
    chk(err_n, 1'b1, "R2", "in reset, clock stopped");

    // R1: clock never starts after reset
    rst_n = 1'b1;
    wait_ref(12);
    chk(err_n, 1'b0, "R1", "never-started clock after reset");
    hold_check(1'b0, "R6", "low held while clock absent");

    // table walk
    for (int i = 0; i < VEC_N; i++) begin
      mon_half = V_HALF[i];
      mon_en   = V_EN[i];
      wait_ref(10);
      hold_check(V_EXP[i], vec_req(i), $sformatf("vector %0d half %0d", i, V_HALF[i]));
    end

    // R9: enable toggle at full rate raises nothing
    mon_half = 5;
    wait_ref(10);
    chk(err_n, 1'b1, "R3", "recovered before enable toggle");
    mon_en = 1'b0;
    wait_ref(2);
    chk(err_n, 1'b1, "R8", "disabled at full rate");
    mon_en = 1'b1;
    hold_check(1'b1, "R9", "no fault without short period or stall");

    // R7: release delay after a slow spell
    mon_half = 400;
    wait_ref(8);
    chk(err_n, 1'b0, "R4", "slow clock before release test");
    hold_check(1'b0, "R6", "low held during slow clock");
    mon_half = 5;
    n = 0;
    up = 1'b0;
    while (!up && n < 2000) begin
      @(posedge mon_clk);
      n++;
      #1;
      if (err_n === 1'b1) up = 1'b1;
    end
    checks++;
    if (!(up && n >= 16 && n <= 416)) begin
      errors++;
      $display("FAIL R7 release after %0d monitored edges (up=%0b), expected 16..416", n, up);
    end

    // R2: reset during a fault
    mon_half = 400;
    wait_ref(8);
    chk(err_n, 1'b0, "R4", "slow clock before reset");
    rst_n = 1'b0;
    #2;
    chk(err_n, 1'b1, "R2", "reset applied during fault");
    wait_ref(2);
    rst_n    = 1'b1;
    mon_half = 5;
    wait_ref(12);
    chk(err_n, 1'b1, "R3", "full rate after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule